// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture Channels

The block is a free-running up-counter behind a programmable prescaler. Four match channels compare their values against the count. On a hit, each channel can independently raise a sticky interrupt flag, force the next count step to zero, stop counting, and update a dedicated output pin through a two-bit action code. Four capture channels synchronise an external input and copy the count into their own register on a chosen edge. Capture events can also raise a sticky flag.

A single-cycle register write port and a combinational read port configure and observe the block. Counting advances only while the run bit is set and the external count-enable input is high. This lets the enclosing design gate the timer from its own clock-enable source.

Top module: `tmr_match_timer`

## Requirements
- R1: After reset, every register, the count, the prescale count, all flags and all match outputs are zero.
- R2: While run is set and `cnt_en_i` is high, the prescale count increments each cycle. Once the prescale count is at or above the limit, it returns to 0 instead, and in that same cycle the main count steps up by one. Otherwise both counts hold.
- R3: While the hold-clear bit (CTRL bit 1) is set, the count and the prescale count are 0 in the following cycle and stay there.
- R4: In the cycle after the count has stepped to a value equal to match value c, channel c signals an event. If match-control bit 3c is set, flag bit c becomes 1 one cycle later.
- R5: While the count equals match value c and match-control bit 3c+1 is set, the next count step loads 0 instead of count+1.
- R6: If match-control bit 3c+2 is set when channel c signals an event, the run bit clears, and this overrides a simultaneous write. The count and the prescale count then hold until run is written to 1 again.
- R7: On a channel-c event, `match_o[c]` follows action field bits [2c+1:2c] one cycle later: 0 keeps it, 1 drives 0, 2 drives 1, 3 inverts it. Without an event it holds.
- R8: Each `cap_i[c]` passes through two synchronising flops. When the synchronised level rises and capture-control bit 3c is set, or falls and bit 3c+1 is set, the capture register takes the count of that cycle.
- R9: A capture event on channel c sets flag bit 4+c when capture-control bit 3c+2 is set.
- R10: Writing to the flag register clears each flag bit written as 1 and leaves bits written as 0 unchanged. A flag set in the same cycle as its clear stays set.
- R11: `irq_o` is high exactly when at least one flag bit is set.
- R12: The register map is:
  - 0: CTRL (bit 0 run, bit 1 hold-clear)
  - 1: prescale limit
  - 2: prescale count
  - 3: count
  - 4: flags
  - 5: match control
  - 6: action fields
  - 7: capture control
  - 8+c: match value c
  - 12+c: capture value c

  Writes to addresses 2, 3 and 12–15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable qualifier |
| cap_i | input | 4 | Capture inputs, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | W | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | W | Read data, combinational |
| count_o | output | W | Current count |
| match_o | output | 4 | Match outputs |
| irq_o | output | 1 | OR of all flags |

## Verification
Two things can collide in one cycle: a flag being set by a match or capture event, and software clearing that same bit with a write-one. The bench keeps a clear of flag bit 0 asserted every cycle while the count wraps quickly through a reset-on-match channel with its interrupt enabled. This forces the set and the clear to coincide repeatedly. A cycle-level reference model, built from the requirements, predicts whether the flag survives; the outputs and the flag register are compared against it. Stop and reset on the same value, and captures landing on increment cycles, are judged the same way.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } ext_act_e;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_PLIM = 4'd1;
  localparam logic [AW-1:0] A_PCNT = 4'd2;
  localparam logic [AW-1:0] A_TCNT = 4'd3;
  localparam logic [AW-1:0] A_FLAG = 4'd4;
  localparam logic [AW-1:0] A_MCTL = 4'd5;
  localparam logic [AW-1:0] A_ECTL = 4'd6;
  localparam logic [AW-1:0] A_CCTL = 4'd7;
  localparam logic [AW-1:0] A_MR0  = 4'd8;
  localparam logic [AW-1:0] A_CR0  = 4'd12;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] pc_o,
  output logic         wrap_o
);
  logic [W-1:0] pc_q;

  // >= so a limit lowered below the current count still wraps
  assign wrap_o = tick_i && (pc_q >= limit_i);
  assign pc_o   = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (clr_i)   pc_q <= '0;
    else if (wrap_o)  pc_q <= '0;
    else if (tick_i)  pc_q <= pc_q + W'(1);
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pc_q == '0));
  a_r3_clr_holds_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pc_q == '0));
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tc_i,
  input  logic         chg_i,
  input  logic [W-1:0] mr_i,
  input  logic [1:0]   act_i,
  output logic         hit_o,
  output logic         evt_o,
  output logic         ext_o
);
  logic ext_q;

  assign hit_o = (tc_i == mr_i);
  assign evt_o = chg_i && hit_o;
  assign ext_o = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else if (evt_o) begin
      unique case (ext_act_e'(act_i))
        ACT_NONE: ext_q <= ext_q;
        ACT_CLR:  ext_q <= 1'b0;
        ACT_SET:  ext_q <= 1'b1;
        ACT_TGL:  ext_q <= ~ext_q;
      endcase
    end
  end

  a_r7_hold_no_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |=> $stable(ext_q));
  a_r7_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && act_i == 2'd3) |=> (ext_q != $past(ext_q)));
  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && act_i == 2'd2) |=> ext_q);
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  logic         rise_en_i,
  input  logic         fall_en_i,
  input  logic [W-1:0] tc_i,
  output logic         cev_o,
  output logic [W-1:0] cap_o
);
  logic s1_q, s2_q, prev_q;
  logic [W-1:0] cap_q;

  assign cev_o = (s2_q && !prev_q && rise_en_i) || (!s2_q && prev_q && fall_en_i);
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (cev_o) cap_q <= tc_i;
    end
  end

  a_r8_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cev_o |=> $stable(cap_q));
  a_r8_cap_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cev_o |=> (cap_q == $past(tc_i)));
endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cnt_en_i,
  input  logic [NCH-1:0] cap_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [W-1:0]   rd_data_o,
  output logic [W-1:0]   count_o,
  output logic [NCH-1:0] match_o,
  output logic           irq_o
);
  localparam int unsigned N  = NCH;
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned FW = 2 * N;

  logic           en_q, crst_q, chg_q;
  logic [W-1:0]   plim_q, tc_q, pc;
  logic [3*N-1:0] mctl_q, cctl_q;
  logic [2*N-1:0] ectl_q;
  logic [FW-1:0]  flag_q, flag_set, flag_clr;
  logic [W-1:0]   mr_q    [N];
  logic [W-1:0]   cap_val [N];

  logic [N-1:0] hit, evt, cev;
  logic [N-1:0] m_irq, m_rst, m_stop, c_rise, c_fall, c_irq;
  logic stop_now, rst_pend, tick, inc;

  assign stop_now = |(evt & m_stop);
  assign rst_pend = |(hit & m_rst);
  assign tick     = cnt_en_i && en_q && !crst_q && !stop_now;

  tmr_prescaler #(.W(W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (crst_q),
    .tick_i  (tick),
    .limit_i (plim_q),
    .pc_o    (pc),
    .wrap_o  (inc)
  );

  for (genvar c = 0; c < N; c++) begin : g_ch
    assign m_irq[c]  = mctl_q[3*c];
    assign m_rst[c]  = mctl_q[3*c+1];
    assign m_stop[c] = mctl_q[3*c+2];
    assign c_rise[c] = cctl_q[3*c];
    assign c_fall[c] = cctl_q[3*c+1];
    assign c_irq[c]  = cctl_q[3*c+2];

    tmr_match_chan #(.W(W)) u_mch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tc_i   (tc_q),
      .chg_i  (chg_q),
      .mr_i   (mr_q[c]),
      .act_i  (ectl_q[2*c +: 2]),
      .hit_o  (hit[c]),
      .evt_o  (evt[c]),
      .ext_o  (match_o[c])
    );

    tmr_capture_chan #(.W(W)) u_cch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (cap_i[c]),
      .rise_en_i (c_rise[c]),
      .fall_en_i (c_fall[c]),
      .tc_i      (tc_q),
      .cev_o     (cev[c]),
      .cap_o     (cap_val[c])
    );
  end

  // main count, run control, configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      crst_q <= 1'b0;
      plim_q <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
      ectl_q <= '0;
      tc_q   <= '0;
      chg_q  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CTRL) begin
        en_q   <= wr_data_i[0];
        crst_q <= wr_data_i[1];
      end
      if (stop_now) en_q <= 1'b0;
      if (wr_en_i && wr_addr_i == A_PLIM) plim_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_MCTL) mctl_q <= wr_data_i[3*N-1:0];
      if (wr_en_i && wr_addr_i == A_CCTL) cctl_q <= wr_data_i[3*N-1:0];
      if (wr_en_i && wr_addr_i == A_ECTL) ectl_q <= wr_data_i[2*N-1:0];

      if (crst_q)      tc_q <= '0;
      else if (inc)    tc_q <= rst_pend ? '0 : tc_q + W'(1);
      chg_q <= inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N; c++) mr_q[c] <= '0;
    end else begin
      for (int c = 0; c < N; c++)
        if (wr_en_i && wr_addr_i == AW'(int'(A_MR0) + c)) mr_q[c] <= wr_data_i;
    end
  end

  // sticky flags: set beats clear
  assign flag_set = {cev & c_irq, evt & m_irq};
  assign flag_clr = (wr_en_i && wr_addr_i == A_FLAG) ? wr_data_i[FW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign irq_o   = |flag_q;
  assign count_o = tc_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = W'({crst_q, en_q});
      A_PLIM:  rd_data_o = plim_q;
      A_PCNT:  rd_data_o = pc;
      A_TCNT:  rd_data_o = tc_q;
      A_FLAG:  rd_data_o = W'(flag_q);
      A_MCTL:  rd_data_o = W'(mctl_q);
      A_ECTL:  rd_data_o = W'(ectl_q);
      A_CCTL:  rd_data_o = W'(cctl_q);
      default: rd_data_o = rd_addr_i[IW] ? cap_val[rd_addr_i[IW-1:0]]
                                         : mr_q[rd_addr_i[IW-1:0]];
    endcase
  end

  a_r3_hold_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crst_q |=> (tc_q == '0));
  a_r5_reload_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && rst_pend && !crst_q) |=> (tc_q == '0));
  a_r6_stop_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_now |=> (!en_q && tc_q == $past(tc_q)));
  a_r2_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tc_q == $past(tc_q) || tc_q == $past(tc_q) + W'(1) || tc_q == '0));
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));
  a_r10_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_clr & ~flag_set) != '0) |=> ((flag_q & $past(flag_clr & ~flag_set)) == '0));
endmodule

// File: tb/sim_tmr_match_timer.sv
module sim_tmr_match_timer;
  localparam int W = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cnt_en_i = 1'b0;
  logic [3:0]    cap_i = '0;
  logic          wr_en_i = 1'b0;
  logic [3:0]    wr_addr_i = '0;
  logic [W-1:0]  wr_data_i = '0;
  logic [3:0]    rd_addr_i = '0;
  logic [W-1:0]  rd_data_o, count_o;
  logic [3:0]    match_o;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  string phase = "R1 reset";

  always #5 clk_i = ~clk_i;

  tmr_match_timer #(.W(W)) u0 (
    .clk_i, .rst_ni, .cnt_en_i, .cap_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .count_o, .match_o, .irq_o
  );

  // reference model
  logic        m_en, m_crst, m_chg;
  logic [31:0] m_plim, m_pc, m_tc;
  logic [7:0]  m_flag, m_ectl;
  logic [11:0] m_mctl, m_cctl;
  logic [31:0] m_mr [4];
  logic [31:0] m_cr [4];
  logic [3:0]  m_mo, m_s1, m_s2, m_pv;

  always @(posedge clk_i or negedge rst_ni) begin : mdl
    logic [3:0] evt, cev;
    logic stop_now, tick, inc, rstp;
    logic [7:0] setv, clrv;
    if (!rst_ni) begin
      m_en = 0; m_crst = 0; m_chg = 0; m_plim = 0; m_pc = 0; m_tc = 0;
      m_flag = 0; m_ectl = 0; m_mctl = 0; m_cctl = 0; m_mo = 0;
      m_s1 = 0; m_s2 = 0; m_pv = 0;
      for (int c = 0; c < 4; c++) begin m_mr[c] = 0; m_cr[c] = 0; end
    end else begin
      rstp = 0; stop_now = 0;
      for (int c = 0; c < 4; c++) begin
        evt[c] = m_chg && (m_tc == m_mr[c]);
        if (evt[c] && m_mctl[3*c+2]) stop_now = 1;
        if (m_tc == m_mr[c] && m_mctl[3*c+1]) rstp = 1;
        cev[c] = (m_s2[c] && !m_pv[c] && m_cctl[3*c]) || (!m_s2[c] && m_pv[c] && m_cctl[3*c+1]);
      end
      tick = cnt_en_i && m_en && !m_crst && !stop_now;
      inc  = tick && (m_pc >= m_plim);
      setv = 0;
      for (int c = 0; c < 4; c++) begin
        if (evt[c] && m_mctl[3*c]) setv[c] = 1;
        if (cev[c] && m_cctl[3*c+2]) setv[4+c] = 1;
        if (cev[c]) m_cr[c] = m_tc;
        if (evt[c]) case (m_ectl[2*c +: 2])
          2'd1: m_mo[c] = 0;
          2'd2: m_mo[c] = 1;
          2'd3: m_mo[c] = ~m_mo[c];
          default: ;
        endcase
      end
      clrv = (wr_en_i && wr_addr_i == 4) ? wr_data_i[7:0] : 8'h0;
      m_flag = (m_flag & ~clrv) | setv;
      if (m_crst) m_pc = 0; else if (inc) m_pc = 0; else if (tick) m_pc = m_pc + 1;
      if (m_crst) m_tc = 0; else if (inc) m_tc = rstp ? 0 : m_tc + 1;
      m_chg = inc;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = cap_i;
      if (wr_en_i) begin
        case (wr_addr_i)
          4'd0: begin m_en = wr_data_i[0]; m_crst = wr_data_i[1]; end
          4'd1: m_plim = wr_data_i;
          4'd5: m_mctl = wr_data_i[11:0];
          4'd6: m_ectl = wr_data_i[7:0];
          4'd7: m_cctl = wr_data_i[11:0];
          4'd8, 4'd9, 4'd10, 4'd11: m_mr[wr_addr_i[1:0]] = wr_data_i;
          default: ;
        endcase
      end
      if (stop_now) m_en = 0;
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return {30'h0, m_crst, m_en};
      4'd1: return m_plim;
      4'd2: return m_pc;
      4'd3: return m_tc;
      4'd4: return {24'h0, m_flag};
      4'd5: return {20'h0, m_mctl};
      4'd6: return {24'h0, m_ectl};
      4'd7: return {20'h0, m_cctl};
      default: return a[2] ? m_cr[a[1:0]] : m_mr[a[1:0]];
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(count_o == m_tc, {phase, " / R2 count"}, count_o, m_tc);
      check(match_o == m_mo, {phase, " / R7 match_o"}, {28'h0, match_o}, {28'h0, m_mo});
      check(irq_o == (|m_flag), {phase, " / R11 irq"}, {31'h0, irq_o}, {31'h0, |m_flag});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    @(negedge clk_i);
    rd_addr_i = a;
    #1;
    check(rd_data_o == model_rd(a), $sformatf("%s rd[%0d]", tag, a), rd_data_o, model_rd(a));
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R1 reset value");
    check(count_o == 0 && match_o == 0 && irq_o == 0, "R1 outputs", {count_o[27:0], match_o}, 0);

    phase = "R2 prescale";
    wr(1, 2); wr(0, 1); cnt_en_i = 1;
    run(30);
    rd_chk(2, "R2");
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_i); cnt_en_i = (i % 3) != 0;
    end
    cnt_en_i = 1;
    rd_chk(3, "R2");

    phase = "R3 hold-clear";
    wr(0, 3); run(10);
    rd_chk(2, "R3"); rd_chk(3, "R3");
    wr(0, 1);

    phase = "R4 R5 R7 match actions";
    wr(1, 0);
    wr(8, 6); wr(9, 2); wr(10, 4); wr(11, 5);
    wr(6, 32'h6C);
    wr(5, 32'h00B);
    run(60);
    rd_chk(4, "R4 flags");
    wr(4, 32'hFF);
    rd_chk(4, "R10 cleared");

    phase = "R10 set-clear collision";
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 4; wr_data_i = 32'h1;
    run(30);
    wr_en_i = 0;
    rd_chk(4, "R10");

    phase = "R6 stop on match";
    wr(5, 32'h80B);
    run(20);
    rd_chk(0, "R6 run bit"); rd_chk(3, "R6 count"); rd_chk(2, "R6 prescale");
    wr(0, 1);
    run(20);
    rd_chk(3, "R6 restart");
    wr(5, 32'h00B); wr(0, 1);

    phase = "R8 R9 capture";
    wr(8, 200); wr(1, 1);
    wr(7, 32'hD5);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i); cap_i = 4'(i * 5 + 3);
      run(4);
      for (int c = 12; c < 16; c++) rd_chk(4'(c), "R8 capture");
    end
    rd_chk(4, "R9 flags");

    phase = "R12 map";
    wr(3, 32'hDEAD); wr(2, 32'h77); wr(12, 32'h55);
    rd_chk(3, "R12 ro count"); rd_chk(12, "R12 ro capture");
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R12 map");
    wr(4, 32'h0); rd_chk(4, "R10 zero write");
    wr(4, 32'hFF); rd_chk(4, "R10 clear all");
    run(5);
    finish_up();
  end
endmodule